// File: doc/BRIEF.md
# Dual-Clock FIFO with Gray-Coded Pointers

This block moves data words from one clock domain into another, where the two clocks have no known phase or frequency relationship. The producer side pushes words with a write enable on its own clock and watches a full flag. The consumer side pops words with a read enable on its own clock and watches an empty flag. The storage is a dual-port register array used as a circular buffer, with a default depth of 256 words.

Each side keeps a binary pointer that is one bit wider than the address, plus a registered Gray copy of that pointer. The Gray copy crosses to the other side through a two-flop synchronizer on every bit and is converted back to binary there. Both flags are deliberately pessimistic by one entry. This covers the one cycle that a synchronizer can lose when it resolves late, so a pointer can never overtake the other.

Top module: `afifo_gray`

## Requirements
- R1: While either reset is low and right after it, full is 0, empty is 1 and rd_data is 0; both pointers start at address zero.
- R2: Words are read out in exactly the order they were written.
- R3: A write request while full is 1 is ignored: no storage location or pointer changes, and the word never appears at the read side.
- R4: A read request while empty is 1 is ignored: rd_data keeps its value and the read pointer does not move.
- R5: full is 1 once the write side sees DEPTH-1 unread entries (write pointer equals synchronized read pointer minus one, modulo the wrap), so at most DEPTH-1 words are held.
- R6: empty is 1 while the read side sees one or zero unread entries, so the final stored word is held back until a further word is written.
- R7: rd_data is registered: it takes the popped word on the read clock edge that accepts the read and holds it otherwise.
- R8: Each registered Gray pointer changes in at most one bit per clock of its domain before it enters a two-flop synchronizer.
- R9: Pointers wrap from address DEPTH-1 back to address 0 with the order of data kept across the wrap.
- R10: Correct operation does not depend on the ratio or phase of the two clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Producer clock |
| wrst_n | input | 1 | Producer reset, active low, asynchronous |
| wr_en | input | 1 | Push request |
| wr_data | input | DW | Word to push |
| full | output | 1 | No further push is accepted |
| rclk | input | 1 | Consumer clock |
| rrst_n | input | 1 | Consumer reset, active low, asynchronous |
| rd_en | input | 1 | Pop request |
| rd_data | output | DW | Last popped word |
| empty | output | 1 | No pop is accepted |

## Verification
On every clock the assertions check that a refused push or pop leaves its pointer still, that the write side never counts more than DEPTH-1 entries and the read side never sees the read pointer pass the write pointer, that each Gray register moves by at most one bit, and that rd_data changes only on an accepted pop. The bench scenarios show the behaviour that depends on both domains at once: data order across a wrap, the point where full rises, the word held back by the pessimistic empty flag, and a refused word that never comes out. The bench runs with two clocks of unrelated periods.

// File: rtl/afifo_pkg.sv
`timescale 1ns/1ps
package afifo_pkg;
  localparam int MAXW = 32;

  // binary -> reflected Gray
  function automatic logic [MAXW-1:0] to_gray(input logic [MAXW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // reflected Gray -> binary: XOR of every right shift
  function automatic logic [MAXW-1:0] from_gray(input logic [MAXW-1:0] g);
    logic [MAXW-1:0] b;
    b = g;
    for (int i = 1; i < MAXW; i++) b = b ^ (g >> i);
    return b;
  endfunction
endpackage

// File: rtl/afifo_sync.sv
`timescale 1ns/1ps
module afifo_sync #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/afifo_wr_ctl.sv
`timescale 1ns/1ps
module afifo_wr_ctl
  import afifo_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic        wclk,
  input  logic        wrst_n,
  input  logic        wr_en,
  input  logic [AW:0] rgray_sync,
  output logic        full,
  output logic        wr_fire,
  output logic [AW-1:0] wr_addr,
  output logic [AW:0] wgray
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin, wbin_nx, rsync_bin, used;

  assign rsync_bin = PW'(from_gray(MAXW'(rgray_sync)));
  assign used      = wbin - rsync_bin;
  assign full      = (used >= PW'(DEPTH - 1));
  assign wr_fire   = wr_en & ~full;
  assign wbin_nx   = wbin + PW'(1);
  assign wr_addr   = wbin[AW-1:0];

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_fire) begin
      wbin  <= wbin_nx;
      wgray <= PW'(to_gray(MAXW'(wbin_nx)));
    end
  end

  p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!wrst_n)
    (wr_en && full) |=> $stable(wbin));
  p_cap_limit_r5: assert property (@(posedge wclk) disable iff (!wrst_n)
    used <= PW'(DEPTH - 1));
  p_wgray_step_r8: assert property (@(posedge wclk) disable iff (!wrst_n)
    $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/afifo_rd_ctl.sv
`timescale 1ns/1ps
module afifo_rd_ctl
  import afifo_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic        rclk,
  input  logic        rrst_n,
  input  logic        rd_en,
  input  logic [AW:0] wgray_sync,
  output logic        empty,
  output logic        rd_fire,
  output logic [AW-1:0] rd_addr,
  output logic [AW:0] rgray
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] rbin, rbin_nx, wsync_bin, avail;

  assign wsync_bin = PW'(from_gray(MAXW'(wgray_sync)));
  assign avail     = wsync_bin - rbin;
  assign empty     = (avail <= PW'(1));
  assign rd_fire   = rd_en & ~empty;
  assign rbin_nx   = rbin + PW'(1);
  assign rd_addr   = rbin[AW-1:0];

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_fire) begin
      rbin  <= rbin_nx;
      rgray <= PW'(to_gray(MAXW'(rbin_nx)));
    end
  end

  p_no_underrun_r4: assert property (@(posedge rclk) disable iff (!rrst_n)
    (rd_en && empty) |=> $stable(rbin));
  p_no_pass_r6: assert property (@(posedge rclk) disable iff (!rrst_n)
    avail <= PW'(DEPTH));
  p_rgray_step_r8: assert property (@(posedge rclk) disable iff (!rrst_n)
    $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/afifo_gray.sv
`timescale 1ns/1ps
module afifo_gray #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          empty
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic          wr_fire, rd_fire;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [PW-1:0] wgray, rgray, wgray_sync, rgray_sync;

  afifo_wr_ctl #(.AW(AW)) u_wr (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .rgray_sync(rgray_sync),
    .full(full), .wr_fire(wr_fire), .wr_addr(wr_addr), .wgray(wgray)
  );

  afifo_rd_ctl #(.AW(AW)) u_rd (
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .wgray_sync(wgray_sync),
    .empty(empty), .rd_fire(rd_fire), .rd_addr(rd_addr), .rgray(rgray)
  );

  // write pointer into the read domain, read pointer into the write domain
  afifo_sync #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rrst_n), .d(wgray), .q(wgray_sync));
  afifo_sync #(.W(PW)) u_r2w (.clk(wclk), .rst_n(wrst_n), .d(rgray), .q(rgray_sync));

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n)      rd_data <= '0;
    else if (rd_fire) rd_data <= mem[rd_addr];
  end

  p_rdata_hold_r7: assert property (@(posedge rclk) disable iff (!rrst_n)
    !rd_fire |=> $stable(rd_data));
endmodule

// File: tb/sim_afifo_gray.sv
`timescale 1ns/1ps
module sim_afifo_gray;
  localparam int CLK_PERIOD = 10;
  localparam int RHALF      = 7;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int DEPTH = 1 << AW;
  localparam int NV = 8;
  localparam logic [DW-1:0] VEC [NV] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80, 8'h3C, 8'hC3};

  logic wclk = 0, rclk = 0, wrst_n = 0, rrst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic full, empty;

  int checks = 0, fails = 0;
  logic [DW-1:0] mdl [1024];
  int head = 0, tail = 0;

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(RHALF) rclk = ~rclk;

  afifo_gray #(.DW(DW), .AW(AW)) u0 (
    .wclk(wclk), .wrst_n(wrst_n), .wr_en(wr_en), .wr_data(wr_data), .full(full),
    .rclk(rclk), .rrst_n(rrst_n), .rd_en(rd_en), .rd_data(rd_data), .empty(empty)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [DW-1:0] d, output bit took);
    @(negedge wclk);
    took = !full;
    wr_en = 1; wr_data = d;
    @(negedge wclk);
    wr_en = 0;
    if (took) begin mdl[tail] = d; tail++; end
  endtask

  task automatic pop(output bit took, output logic [DW-1:0] d);
    @(negedge rclk);
    took = !empty;
    rd_en = 1;
    @(negedge rclk);
    rd_en = 0;
    d = rd_data;
  endtask

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    bit took;
    logic [DW-1:0] d, prev;
    int n;
    repeat (4) @(negedge wclk);
    // R1: reset state
    chk("R1 full", full, 0);
    chk("R1 empty", empty, 1);
    chk("R1 rd_data", rd_data, 0);
    wrst_n = 1; rrst_n = 1;
    settle();
    chk("R1 empty after release", empty, 1);

    // R4: pop while empty ignored
    pop(took, d);
    chk("R4 rd_data held", d, 0);
    chk("R4 still empty", empty, 1);

    // vector table: push all, pop all but the held-back last word
    for (int i = 0; i < NV; i++) begin
      push(VEC[i], took);
      chk("R2 push accepted", took, 1);
    end
    settle();
    for (int i = 0; i < NV - 1; i++) begin
      @(negedge rclk);
      prev = rd_data;
      chk("R7 rd_data before pop", prev, (i == 0) ? 8'h00 : VEC[i-1]);
      pop(took, d);
      chk("R2 R10 order", d, VEC[i]);
      head++;
    end
    settle();
    chk("R6 last word held back", empty, 1);
    push(8'h77, took);
    settle();
    chk("R6 released by next write", empty, 0);
    pop(took, d);
    chk("R6 held word", d, VEC[NV-1]);
    head++;
    settle();
    chk("R6 empty with one left", empty, 1);

    // fill until full
    n = 0;
    for (int i = 0; i < 2 * DEPTH; i++) begin
      @(negedge wclk);
      if (full) break;
      push(8'(i + 16), took);
      if (took) n++;
    end
    chk("R5 accepted count", n, DEPTH - 2);
    chk("R5 full", full, 1);

    // R3: push while full ignored
    push(8'hEE, took);
    settle();
    chk("R3 still full", full, 1);

    // drain, crossing the address wrap
    n = 0;
    for (int i = 0; i < 2 * DEPTH; i++) begin
      @(negedge rclk);
      if (empty) break;
      pop(took, d);
      if (d !== mdl[head]) chk("R9 R3 drain data", d, mdl[head]);
      head++; n++;
    end
    chk("R9 drained count", n, DEPTH - 2);
    chk("R9 last data", d, mdl[head-1]);
    chk("R6 one word left", tail - head, 1);
    chk("R5 full cleared", full, 0);
    summary();
  end
endmodule